// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is a central scoreboard for an in-order issue stage feeding a set of unpipelined functional units. Each incoming instruction names a unit type, one destination register and two source registers, plus an execution latency. Execution is modelled inside the block as a countdown per unit. The block decides three things: when the instruction may leave the issue stage (dispatch), when its operands may be read, and when its finished result may take the single register write port.

There are `NU` units, and unit `u` has type `u % NT`. Instructions dispatch strictly in arrival order. An instruction waits at the input when no unit of its type is free, or when its destination already has a pending writer. Once dispatched it waits inside its unit until both sources have no outstanding producer. It then counts down its latency and holds the result until writing cannot destroy a value that an older instruction still needs to read. Register contents, forwarding and exceptions are handled elsewhere. Register specifiers are 3 bits wide, so there are 8 architectural registers.

Top module: `scoreboard_issue`

## Requirements
- R1: After reset no unit is busy and no register is pending, so `in_ready` is 1, `wb_valid` is 0 and `rd_fire` is all zeros.
- R2: `in_ready` is 1 only when some idle unit has type equal to `in_type` (unit u has type u mod NT). On acceptance (`in_valid` and `in_ready` at a rising edge), the instruction goes to the lowest-numbered such unit, reported on `disp_unit` in the same cycle.
- R3: `in_ready` is 0 while `in_dst` has a pending writer, so each register has at most one outstanding writer.
- R4: A dispatched unit raises its `rd_fire` bit in the first cycle after dispatch in which neither source has a pending writer that was dispatched earlier. For an instruction with no such dependence, this is the cycle right after dispatch.
- R5: After `rd_fire` in cycle r, an instruction with latency L (1 to 2^LW-1; 0 acts as 1) is complete, and may write back, from cycle r+L+1 on.
- R6: A complete unit does not write back while any older dispatched unit that has not yet raised `rd_fire` names that unit's destination as either source.
- R7: When several complete units may write back, only the oldest by dispatch order is granted. `wb_valid`, `wb_unit` and `wb_dst` describe the granted write.
- R8: In a write-back cycle the unit becomes idle and its destination's pending mark is cleared, both effective from the next cycle.
- R9: A waiting consumer's source becomes ready when its producer writes back. The consumer may raise `rd_fire` in the next cycle, and this also holds when the consumer is accepted in the very cycle of that write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_type | input | $clog2(NT) | Required unit type |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| in_lat | input | LW | Execution latency in cycles |
| in_ready | output | 1 | The offered instruction is accepted at the next edge |
| disp_unit | output | $clog2(NU) | Unit that receives the offered instruction |
| rd_fire | output | NU | Per unit: operands are read this cycle |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_unit | output | $clog2(NU) | Unit writing back |
| wb_dst | output | 3 | Register written back |

## Verification
`in_ready` and `disp_unit` are combinational on the offered instruction and the current state. They are compared in the same cycle. A dispatch takes effect at the following edge, so `rd_fire` of an independent instruction is expected one cycle after acceptance, and one cycle after the producer's write-back when there is a dependence. A write-back is expected from L+1 cycles after the operand-read cycle, and later when an older reader or an older complete unit holds it off. The bench keeps its own record of every unit and register from the observed events. In the middle of each cycle it predicts every one of these outputs and compares them, and only then does it apply that cycle's events to its record.

// File: rtl/scoreboard_issue.sv
module scoreboard_issue #(
  parameter int NU = 4,
  parameter int NT = 2,
  parameter int LW = 4,
  parameter int RW = 3,
  localparam int UW = $clog2(NU),
  localparam int TW = $clog2(NT),
  localparam int NR = 2 ** RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [TW-1:0] in_type,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_src1,
  input  logic [RW-1:0] in_src2,
  input  logic [LW-1:0] in_lat,
  output logic          in_ready,
  output logic [UW-1:0] disp_unit,
  output logic [NU-1:0] rd_fire,
  output logic          wb_valid,
  output logic [UW-1:0] wb_unit,
  output logic [RW-1:0] wb_dst
);

  logic [NU-1:0] busy, waiting, done, r1, r2;
  logic [NU-1:0][RW-1:0] dst, s1, s2;
  logic [NU-1:0][UW-1:0] q1, q2;
  logic [NU-1:0][LW-1:0] lat, cnt;
  logic [NU-1:0][NU-1:0] older;
  logic [NR-1:0] pend;
  logic [NR-1:0][UW-1:0] owner;

  logic [NU-1:0] free_ok, war_blk, elig, grant, exec;
  logic          acc;

  assign exec    = busy & ~waiting & ~done;
  assign rd_fire = waiting & r1 & r2;
  assign elig    = done & ~war_blk;

  always_comb begin
    free_ok   = '0;
    disp_unit = '0;
    war_blk   = '0;
    for (int i = 0; i < NU; i++)
      free_ok[i] = !busy[i] && (TW'(i % NT) == in_type);
    for (int i = NU - 1; i >= 0; i--)
      if (free_ok[i]) disp_unit = UW'(i);
    for (int i = 0; i < NU; i++)
      for (int j = 0; j < NU; j++)
        if (older[i][j] && waiting[j] && (s1[j] == dst[i] || s2[j] == dst[i]))
          war_blk[i] = 1'b1;
  end

  always_comb begin
    grant   = '0;
    wb_unit = '0;
    for (int i = 0; i < NU; i++) begin
      grant[i] = elig[i];
      for (int j = 0; j < NU; j++)
        if (elig[j] && older[i][j]) grant[i] = 1'b0;
    end
    for (int i = 0; i < NU; i++)
      if (grant[i]) wb_unit = UW'(i);
  end

  assign in_ready = (|free_ok) && !pend[in_dst];
  assign acc      = in_valid && in_ready;
  assign wb_valid = |grant;
  assign wb_dst   = dst[wb_unit];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0; waiting <= '0; done <= '0; r1 <= '0; r2 <= '0;
      dst <= '0; s1 <= '0; s2 <= '0; q1 <= '0; q2 <= '0;
      lat <= '0; cnt <= '0; older <= '0; pend <= '0; owner <= '0;
    end else begin
      for (int i = 0; i < NU; i++) begin
        if (exec[i]) begin
          if (cnt[i] <= LW'(1)) done[i] <= 1'b1;
          else cnt[i] <= cnt[i] - LW'(1);
        end
        if (rd_fire[i]) begin
          waiting[i] <= 1'b0;
          cnt[i]     <= lat[i];
        end
        if (wb_valid && waiting[i] && !r1[i] && q1[i] == wb_unit) r1[i] <= 1'b1;
        if (wb_valid && waiting[i] && !r2[i] && q2[i] == wb_unit) r2[i] <= 1'b1;
        if (grant[i]) begin
          busy[i] <= 1'b0;
          done[i] <= 1'b0;
        end
      end
      if (acc) begin
        busy[disp_unit]    <= 1'b1;
        waiting[disp_unit] <= 1'b1;
        done[disp_unit]    <= 1'b0;
        dst[disp_unit]     <= in_dst;
        s1[disp_unit]      <= in_src1;
        s2[disp_unit]      <= in_src2;
        lat[disp_unit]     <= in_lat;
        q1[disp_unit]      <= owner[in_src1];
        q2[disp_unit]      <= owner[in_src2];
        r1[disp_unit]      <= !pend[in_src1] || (wb_valid && wb_dst == in_src1);
        r2[disp_unit]      <= !pend[in_src2] || (wb_valid && wb_dst == in_src2);
        for (int x = 0; x < NU; x++) begin
          older[x][disp_unit] <= 1'b0;
          older[disp_unit][x] <= busy[x] && !grant[x];
        end
      end
      if (wb_valid) pend[wb_dst] <= 1'b0;
      if (acc) begin
        pend[in_dst]  <= 1'b1;
        owner[in_dst] <= disp_unit;
      end
    end
  end

endmodule

// File: rtl/scoreboard_issue_chk.sv
module scoreboard_issue_chk #(
  parameter int NU = 4,
  parameter int UW = 2,
  parameter int RW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [UW-1:0]      disp_unit,
  input logic [RW-1:0]      in_dst,
  input logic               wb_valid,
  input logic [UW-1:0]      wb_unit,
  input logic [RW-1:0]      wb_dst,
  input logic [NU-1:0]      busy,
  input logic [NU-1:0]      done,
  input logic [2**RW-1:0]   pend
);

  AST_DISP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> !busy[disp_unit]); // R2

  AST_DISP_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> pend[$past(in_dst)] && busy[$past(disp_unit)]); // R3

  AST_WB_FROM_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy[wb_unit] && pend[wb_dst]); // R7

  AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !pend[$past(wb_dst)] && !busy[$past(wb_unit)]); // R8

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done & ~busy) == '0); // R5

endmodule

bind scoreboard_issue scoreboard_issue_chk #(.NU(NU), .UW(UW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .disp_unit(disp_unit), .in_dst(in_dst), .wb_valid(wb_valid),
  .wb_unit(wb_unit), .wb_dst(wb_dst), .busy(busy), .done(done), .pend(pend)
);

// File: tb/scoreboard_issue_bench.sv
`timescale 1ns/1ps
module scoreboard_issue_bench;
  localparam int NU = 4, NT = 2, LW = 4, RW = 3;
  localparam int UW = $clog2(NU), TW = $clog2(NT), NR = 2 ** RW;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [TW-1:0] in_type = '0;
  logic [RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [LW-1:0] in_lat = '0;
  logic in_ready, wb_valid;
  logic [UW-1:0] disp_unit, wb_unit;
  logic [NU-1:0] rd_fire;
  logic [RW-1:0] wb_dst;

  scoreboard_issue #(.NU(NU), .NT(NT), .LW(LW), .RW(RW)) u_scoreboard_issue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_lat(in_lat),
    .in_ready(in_ready), .disp_unit(disp_unit), .rd_fire(rd_fire),
    .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_dst(wb_dst));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, seqctr = 0;
  bit mon_on = 0, finished = 0;
  bit b_busy[NU], b_read[NU];
  int b_rdc[NU], b_lat[NU], b_dst[NU], b_s1[NU], b_s2[NU], b_d1[NU], b_d2[NU], b_seq[NU];
  bit b_pend[NR];
  int b_own[NR];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int eff_lat(int l);
    return (l == 0) ? 1 : l;
  endfunction

  function automatic bit is_done(int u);
    return b_busy[u] && b_read[u] && (cyc >= b_rdc[u] + eff_lat(b_lat[u]) + 1);
  endfunction

  function automatic bit war_held(int u);
    for (int j = 0; j < NU; j++)
      if (b_busy[j] && !b_read[j] && b_seq[j] < b_seq[u] &&
          (b_s1[j] == b_dst[u] || b_s2[j] == b_dst[u])) return 1;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      int exp_unit, best, bseq, pu;
      bit any_free, exp_rdy;
      cyc++;
      any_free = 0; exp_unit = 0;
      for (int u = NU - 1; u >= 0; u--)
        if (!b_busy[u] && (u % NT) == int'(in_type)) begin any_free = 1; exp_unit = u; end
      exp_rdy = any_free && !b_pend[in_dst];
      if (b_pend[in_dst]) chk("R3", "in_ready with pending destination", int'(in_ready), 0);
      else chk("R2", "in_ready", int'(in_ready), int'(exp_rdy));
      if (exp_rdy) chk("R2", "disp_unit", int'(disp_unit), exp_unit);
      for (int u = 0; u < NU; u++)
        chk(b_d1[u] >= 0 || b_d2[u] >= 0 ? "R9" : "R4", "rd_fire bit",
            int'(rd_fire[u]), int'(b_busy[u] && !b_read[u] && b_d1[u] < 0 && b_d2[u] < 0));
      best = -1; bseq = 0;
      for (int u = 0; u < NU; u++)
        if (is_done(u) && !war_held(u) && (best < 0 || b_seq[u] < bseq)) begin best = u; bseq = b_seq[u]; end
      chk("R5", "wb_valid", int'(wb_valid), int'(best >= 0));
      if (best >= 0 && wb_valid) begin
        chk("R7", "wb_unit (oldest eligible)", int'(wb_unit), best);
        chk("R7", "wb_dst", int'(wb_dst), b_dst[best]);
      end
      for (int u = 0; u < NU; u++)
        if (wb_valid && int'(wb_unit) == u && is_done(u) && war_held(u))
          chk("R6", "write-back while older reader waits", 1, 0);
      if (wb_valid) begin
        pu = int'(wb_unit);
        b_busy[pu] = 0;
        b_pend[b_dst[pu]] = 0;
        for (int u = 0; u < NU; u++) begin
          if (b_d1[u] == pu) b_d1[u] = -1;
          if (b_d2[u] == pu) b_d2[u] = -1;
        end
      end
      for (int u = 0; u < NU; u++)
        if (rd_fire[u]) begin b_read[u] = 1; b_rdc[u] = cyc; end
      if (in_valid && in_ready) begin
        pu = int'(disp_unit);
        b_busy[pu] = 1; b_read[pu] = 0;
        b_dst[pu] = int'(in_dst); b_s1[pu] = int'(in_src1); b_s2[pu] = int'(in_src2);
        b_lat[pu] = int'(in_lat); b_seq[pu] = seqctr++;
        b_d1[pu] = b_pend[in_src1] ? b_own[in_src1] : -1;
        b_d2[pu] = b_pend[in_src2] ? b_own[in_src2] : -1;
        b_pend[in_dst] = 1; b_own[in_dst] = pu;
      end
    end
  end

  task automatic issue(int t, int d, int a, int b, int l);
    bit took;
    in_valid = 1; in_type = TW'(t); in_dst = RW'(d);
    in_src1 = RW'(a); in_src2 = RW'(b); in_lat = LW'(l);
    took = 0;
    while (!took) begin
      @(negedge clk); took = in_ready;
      @(posedge clk); #1;
    end
    in_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int u = 0; u < NU; u++) begin b_busy[u] = 0; b_read[u] = 0; b_d1[u] = -1; b_d2[u] = -1; end
    for (int r = 0; r < NR; r++) b_pend[r] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
    chk("R1", "wb_valid after reset", int'(wb_valid), 0);
    chk("R1", "rd_fire after reset", int'(rd_fire), 0);
    @(posedge clk); #1;
    mon_on = 1;
    // R4/R9 RAW chain with a write-back in the consumer's dispatch cycle region
    issue(0, 1, 0, 0, 3);
    issue(1, 2, 1, 1, 1);
    issue(0, 3, 2, 1, 2);
    idle(12);
    // R3 WAW stall
    issue(0, 4, 0, 0, 6);
    issue(1, 4, 0, 0, 1);
    idle(12);
    // R6 WAR hold: older reader of r5 waits on long producer, younger writer of r5 finishes first
    issue(0, 1, 0, 0, 8);
    issue(1, 2, 1, 5, 1);
    issue(0, 5, 0, 0, 1);
    idle(16);
    // R7 simultaneous completion across types, R2 unit exhaustion
    issue(0, 1, 0, 0, 2);
    issue(1, 2, 0, 0, 1);
    issue(0, 3, 0, 0, 1);
    issue(1, 6, 0, 0, 1);
    issue(0, 7, 0, 0, 1);
    idle(12);
    // constrained random mix
    for (int n = 0; n < 500; n++) begin
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
      issue($urandom % NT, $urandom % NR, $urandom % NR, $urandom % NR, $urandom % 7);
    end
    idle(80);
    for (int u = 0; u < NU; u++) chk("R8", "unit idle after drain", int'(b_busy[u]), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule